// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

This block collects up to `NUM_LINES` interrupt request lines. Each line has its own 4-bit priority, an enable bit and a pending bit. Every cycle it picks the most urgent request that is both pending and enabled. It offers that request to the processor as one beat carrying the channel number, the priority and the handler vector address. The offer is made only when the request outranks the handler that is currently running. Software programs priorities and enables, and can set or clear pending bits, through a single-beat write port.

The processor side is a valid/ready handshake. `core_req_valid` rises when a qualifying request exists. The beat is taken in any cycle where `core_req_valid` and `core_req_ready` are both high. The payload is not frozen while valid waits for ready. If a request with strictly better priority arrives during that wait, it replaces the offered beat, so the core always enters the most urgent handler. Valid can also drop if the offered request is withdrawn by software before it is taken.

Accepting a beat moves the channel from pending to active. A one-cycle `core_exit` pulse retires the innermost active handler. In the exit cycle itself, requests are compared against the next outer level. This lets the core chain the next handler in the same cycle, with no idle gap.

Top module: `prio_vec_arbiter`

## Requirements
- R1: Channels are numbered 0 to NUM_LINES-1. An offered beat carries the channel number, that channel's priority, and the vector `VEC_BASE + channel * VEC_STRIDE`.
- R2: A rising edge on `irq_in[c]` (low in one cycle, high in the next) sets pending for channel c. A line held high causes no further pending after the first.
- R3: A write uses `cfg_wr_addr = {kind[1:0], channel[5:0]}`. Kind 0 sets the priority to `cfg_wr_data[3:0]`. Kind 1 sets the enable to `cfg_wr_data[0]`. Kind 2 sets pending when `cfg_wr_data[0]`=1 and clears it when 0. A hardware edge in the same cycle wins over a clear.
- R4: Among channels that are both pending and enabled, the lowest priority value is selected. Ties go to the lowest channel number.
- R5: A disabled channel keeps its pending bit but is never offered. Enabling it later makes it eligible at once.
- R6: A request is offered only if its priority value is strictly less than the running priority. The running priority is that of the innermost active handler; with no active handler, any eligible request qualifies.
- R7: While valid is high and not yet accepted, a newly eligible request with a strictly lower priority value replaces the offered beat.
- R8: When valid and ready are both high, the channel's pending bit is cleared and it becomes active.
- R9: `core_exit` retires the innermost active handler; it is ignored if no handler is active. During the exit cycle, requests are qualified against the next outer active level, so a chained beat can be offered and accepted in that same cycle.
- R10: After reset, nothing is pending, enabled or active, all priorities are 0, and `core_req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_LINES | Interrupt request lines, edge captured |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | CH_W+2 | Write kind (upper two bits) and channel |
| cfg_wr_data | input | PRIO_W | Write data |
| core_req_valid | output | 1 | A qualifying request is offered |
| core_req_ready | input | 1 | Core accepts the offered beat |
| core_req_vec | output | VEC_W | Handler vector address |
| core_req_chan | output | CH_W | Offered channel number |
| core_req_prio | output | PRIO_W | Offered channel priority |
| core_exit | input | 1 | Retire innermost active handler |

## Verification
Corrupted pending, enable or active state shows up at the handshake ports in the first cycle it matters. A wrong channel is offered, valid rises when it should not, or valid fails to rise. This happens either in the cycle right after the faulty edge or write, or in the exit cycle where a chained beat is due. The scoreboard compares channel, priority and vector on every accepted beat. Direct probes check valid within one cycle after each stimulus, which catches a lost preemption, a wrong tie-break or a missed tail chain immediately.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  typedef enum logic [1:0] {
    CFG_PRIO   = 2'd0,
    CFG_ENABLE = 2'd1,
    CFG_PEND   = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/prio_line_bank.sv
module prio_line_bank #(
  parameter int N  = 60,
  parameter int PW = 4,
  parameter int CW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    irq_in,
  input  logic            wr_en,
  input  logic [1:0]      wr_kind,
  input  logic [CW-1:0]   wr_chan,
  input  logic [PW-1:0]   wr_data,
  input  logic            acc_en,
  input  logic [CW-1:0]   acc_chan,
  input  logic            exit_en,
  input  logic [CW-1:0]   exit_chan,
  output logic [N-1:0]    pend,
  output logic [N-1:0]    enab,
  output logic [N*PW-1:0] prio_flat,
  output logic [N-1:0]    active
);
  import prio_arb_pkg::*;

  logic [N-1:0] irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_in;
  end

  for (genvar c = 0; c < N; c++) begin : g_line
    logic hit, edge_seen, sw_set, sw_clr, acc_hit, exit_hit;
    assign hit       = wr_en && (wr_chan == CW'(c));
    assign edge_seen = irq_in[c] && !irq_q[c];
    assign sw_set    = hit && (wr_kind == CFG_PEND) && wr_data[0];
    assign sw_clr    = hit && (wr_kind == CFG_PEND) && !wr_data[0];
    assign acc_hit   = acc_en && (acc_chan == CW'(c));
    assign exit_hit  = exit_en && (exit_chan == CW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[c]                 <= 1'b0;
        enab[c]                 <= 1'b0;
        active[c]               <= 1'b0;
        prio_flat[c*PW +: PW]   <= '0;
      end else begin
        if (edge_seen || sw_set)     pend[c] <= 1'b1;
        else if (acc_hit || sw_clr)  pend[c] <= 1'b0;

        if (hit && wr_kind == CFG_ENABLE) enab[c] <= wr_data[0];
        if (hit && wr_kind == CFG_PRIO)   prio_flat[c*PW +: PW] <= wr_data;

        if (acc_hit)       active[c] <= 1'b1;
        else if (exit_hit) active[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prio_min_select.sv
module prio_min_select #(
  parameter int N  = 60,
  parameter int PW = 4,
  parameter int CW = 6
) (
  input  logic [N-1:0]    mask,
  input  logic [N*PW-1:0] prio_flat,
  output logic            found,
  output logic [CW-1:0]   idx,
  output logic [PW-1:0]   best_prio
);
  always_comb begin
    found     = 1'b0;
    idx       = '0;
    best_prio = '0;
    for (int i = 0; i < N; i++) begin
      if (mask[i] && (!found || prio_flat[i*PW +: PW] < best_prio)) begin
        found     = 1'b1;
        idx       = CW'(i);
        best_prio = prio_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/prio_vec_arbiter.sv
module prio_vec_arbiter #(
  parameter int          NUM_LINES  = 60,
  parameter int          PRIO_W     = 4,
  parameter int          VEC_W      = 32,
  parameter logic [31:0] VEC_BASE   = 32'h0000_0040,
  parameter logic [31:0] VEC_STRIDE = 32'h0000_0004,
  localparam int         CH_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 cfg_wr_en,
  input  logic [CH_W+1:0]      cfg_wr_addr,
  input  logic [PRIO_W-1:0]    cfg_wr_data,
  output logic                 core_req_valid,
  input  logic                 core_req_ready,
  output logic [VEC_W-1:0]     core_req_vec,
  output logic [CH_W-1:0]      core_req_chan,
  output logic [PRIO_W-1:0]    core_req_prio,
  input  logic                 core_exit
);
  logic [NUM_LINES-1:0]        line_pend, line_enab, line_active;
  logic [NUM_LINES*PRIO_W-1:0] line_prio;
  logic [NUM_LINES-1:0]        outer_mask;

  logic              cand_found, inner_found, outer_found;
  logic [CH_W-1:0]   cand_idx, inner_idx, outer_idx;
  logic [PRIO_W-1:0] cand_prio, inner_prio, outer_prio;
  logic              run_found;
  logic [PRIO_W-1:0] run_prio;
  logic              accept, retire;

  prio_line_bank #(.N(NUM_LINES), .PW(PRIO_W), .CW(CH_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .wr_en     (cfg_wr_en),
    .wr_kind   (cfg_wr_addr[CH_W+1:CH_W]),
    .wr_chan   (cfg_wr_addr[CH_W-1:0]),
    .wr_data   (cfg_wr_data),
    .acc_en    (accept),
    .acc_chan  (cand_idx),
    .exit_en   (retire),
    .exit_chan (inner_idx),
    .pend      (line_pend),
    .enab      (line_enab),
    .prio_flat (line_prio),
    .active    (line_active)
  );

  // Most urgent eligible request
  prio_min_select #(.N(NUM_LINES), .PW(PRIO_W), .CW(CH_W)) u_sel_cand (
    .mask      (line_pend & line_enab),
    .prio_flat (line_prio),
    .found     (cand_found),
    .idx       (cand_idx),
    .best_prio (cand_prio)
  );

  // Innermost running handler
  prio_min_select #(.N(NUM_LINES), .PW(PRIO_W), .CW(CH_W)) u_sel_inner (
    .mask      (line_active),
    .prio_flat (line_prio),
    .found     (inner_found),
    .idx       (inner_idx),
    .best_prio (inner_prio)
  );

  assign outer_mask = line_active & ~(NUM_LINES'(1) << inner_idx);

  // Level that becomes current once the innermost handler retires
  prio_min_select #(.N(NUM_LINES), .PW(PRIO_W), .CW(CH_W)) u_sel_outer (
    .mask      (outer_mask),
    .prio_flat (line_prio),
    .found     (outer_found),
    .idx       (outer_idx),
    .best_prio (outer_prio)
  );

  assign retire = core_exit && inner_found;

  always_comb begin
    if (retire) begin
      run_found = outer_found;
      run_prio  = outer_prio;
    end else begin
      run_found = inner_found;
      run_prio  = inner_prio;
    end
  end

  assign core_req_valid = cand_found && (!run_found || cand_prio < run_prio);
  assign core_req_chan  = cand_idx;
  assign core_req_prio  = cand_prio;
  assign core_req_vec   = VEC_W'(VEC_BASE + 32'(cand_idx) * VEC_STRIDE);
  assign accept         = core_req_valid && core_req_ready;
endmodule

// File: rtl/prio_vec_arbiter_chk.sv
module prio_vec_arbiter_chk #(
  parameter int N    = 60,
  parameter int PW   = 4,
  parameter int CW   = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_req_valid,
  input logic          core_req_ready,
  input logic [CW-1:0] core_req_chan,
  input logic [PW-1:0] core_req_prio,
  input logic          core_exit,
  input logic          cfg_wr_en,
  input logic [N-1:0]  line_enab,
  input logic [N-1:0]  line_active,
  input logic          inner_found,
  input logic          outer_found,
  input logic [CW-1:0] outer_idx
);
  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_valid |-> (int'(core_req_chan) < N)); // R1
  AST_OFFER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_valid |-> line_enab[core_req_chan]); // R5
  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && core_req_ready && !core_exit && !cfg_wr_en) ##1 (core_req_valid && !core_exit) |-> (core_req_prio < $past(core_req_prio))); // R6
  AST_ACCEPT_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && core_req_ready) |=> line_active[$past(core_req_chan)]); // R8
  AST_EXIT_KEEPS_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
    (core_exit && inner_found && outer_found) |=> line_active[$past(outer_idx)]); // R9
endmodule

bind prio_vec_arbiter prio_vec_arbiter_chk #(.N(NUM_LINES), .PW(PRIO_W), .CW(CH_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_req_valid (core_req_valid),
  .core_req_ready (core_req_ready),
  .core_req_chan  (core_req_chan),
  .core_req_prio  (core_req_prio),
  .core_exit      (core_exit),
  .cfg_wr_en      (cfg_wr_en),
  .line_enab      (line_enab),
  .line_active    (line_active),
  .inner_found    (inner_found),
  .outer_found    (outer_found),
  .outer_idx      (outer_idx)
);

// File: tb/test_prio_vec_arbiter.sv
module test_prio_vec_arbiter;
  localparam int          N      = 60;
  localparam int          PW     = 4;
  localparam int          CW     = 6;
  localparam logic [31:0] BASE   = 32'h0000_0100;
  localparam logic [31:0] STRIDE = 32'h0000_0008;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic          cfg_wr_en;
  logic [CW+1:0] cfg_wr_addr;
  logic [PW-1:0] cfg_wr_data;
  logic          core_req_valid, core_req_ready, core_exit;
  logic [31:0]   core_req_vec;
  logic [CW-1:0] core_req_chan;
  logic [PW-1:0] core_req_prio;

  always #10 clk = ~clk;

  prio_vec_arbiter #(.NUM_LINES(N), .PRIO_W(PW), .VEC_W(32),
                     .VEC_BASE(BASE), .VEC_STRIDE(STRIDE)) i_prio_vec_arbiter (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_vec(core_req_vec), .core_req_chan(core_req_chan),
    .core_req_prio(core_req_prio), .core_exit(core_exit)
  );

  int vec_cnt = 0;
  int err_cnt = 0;
  int exp_q[$];
  int exp_prio[N];

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vec_cnt++;
    if (got !== exp) begin
      err_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic probe(input string tag, input bit vld, input int ch);
    #1;
    check({tag, " valid"}, 32'(core_req_valid), 32'(vld));
    if (vld) check({tag, " chan"}, 32'(core_req_chan), 32'(ch));
  endtask

  task automatic cfg(input logic [1:0] kind, input int ch, input int data);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_addr = {kind, CW'(ch)};
    cfg_wr_data = PW'(data);
    if (kind == 2'd0) exp_prio[ch] = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); irq_in[ch] = 1'b1;
    @(negedge clk); irq_in[ch] = 1'b0;
  endtask

  task automatic take(input int ch);
    @(negedge clk); exp_q.push_back(ch); core_req_ready = 1'b1;
    @(negedge clk); core_req_ready = 1'b0;
  endtask

  task automatic leave();
    @(negedge clk); core_exit = 1'b1;
    @(negedge clk); core_exit = 1'b0;
  endtask

  // Monitor: compares each accepted beat against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk); #8;
      if (rst_n && core_req_valid && core_req_ready) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected accept chan", 32'(core_req_chan), 32'hFFFF_FFFF);
        end else begin
          int e;
          e = exp_q.pop_front();
          check("R4 accepted chan", 32'(core_req_chan), 32'(e));
          check("R1 accepted prio", 32'(core_req_prio), 32'(exp_prio[e]));
          check("R1 accepted vec", core_req_vec, BASE + 32'(e) * STRIDE);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    vec_cnt++; err_cnt++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) exp_prio[i] = 0;
    rst_n = 1'b0; irq_in = '0; cfg_wr_en = 1'b0; cfg_wr_addr = '0;
    cfg_wr_data = '0; core_req_ready = 1'b0; core_exit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    probe("R10 reset", 1'b0, 0);

    // Edge on a never-enabled line after reset: no offer
    pulse(7);
    probe("R10 enables cleared", 1'b0, 0);
    cfg(2'd2, 7, 0);

    cfg(2'd0, 5, 3); cfg(2'd0, 9, 3); cfg(2'd0, 20, 1); cfg(2'd0, 40, 7);
    cfg(2'd1, 5, 1); cfg(2'd1, 9, 1); cfg(2'd1, 20, 1); cfg(2'd1, 40, 1);

    // Tie goes to lowest channel; equal priority does not preempt; tail chain
    @(negedge clk); irq_in[5] = 1'b1; irq_in[9] = 1'b1;
    @(negedge clk); irq_in[5] = 1'b0; irq_in[9] = 1'b0;
    probe("R4 tie low index", 1'b1, 5);
    take(5);
    probe("R6 equal prio blocked", 1'b0, 0);
    @(negedge clk); core_exit = 1'b1; core_req_ready = 1'b1; exp_q.push_back(9);
    probe("R9 tail chain same cycle", 1'b1, 9);
    @(negedge clk); core_exit = 1'b0; core_req_ready = 1'b0;
    leave();
    probe("R9 all retired", 1'b0, 0);

    // Late arrival replaces offered beat; nested preemption
    pulse(40);
    probe("R4 single", 1'b1, 40);
    pulse(20);
    probe("R7 late arrival", 1'b1, 20);
    take(20);
    probe("R6 lower prio blocked", 1'b0, 0);
    leave();
    probe("R9 next after exit", 1'b1, 40);
    take(40);
    pulse(20);
    probe("R6 strict preempt", 1'b1, 20);
    take(20);
    leave();
    probe("R9 outer still running", 1'b0, 0);
    leave();

    // Exit with nothing active is ignored
    leave();
    probe("R9 idle exit", 1'b0, 0);

    // Software pending set / clear; edge beats clear
    cfg(2'd2, 9, 1);
    probe("R3 sw set", 1'b1, 9);
    cfg(2'd2, 9, 0);
    probe("R3 sw clear", 1'b0, 0);
    @(negedge clk);
    irq_in[9] = 1'b1; cfg_wr_en = 1'b1; cfg_wr_addr = {2'd2, CW'(9)}; cfg_wr_data = '0;
    @(negedge clk); cfg_wr_en = 1'b0;
    probe("R3 edge wins over clear", 1'b1, 9);
    take(9);
    leave();
    irq_in[9] = 1'b0;

    // Disabled channel keeps pending
    cfg(2'd0, 30, 0);
    pulse(30);
    probe("R5 disabled hidden", 1'b0, 0);
    cfg(2'd1, 30, 1);
    probe("R5 enable reveals", 1'b1, 30);
    take(30);
    leave();

    // Held level pends once only
    @(negedge clk); irq_in[40] = 1'b1;
    @(negedge clk);
    probe("R2 rising edge", 1'b1, 40);
    take(40);
    leave();
    repeat (3) @(negedge clk);
    probe("R2 held level no repend", 1'b0, 0);
    irq_in[40] = 1'b0;

    // Priority ordering among several pending
    cfg(2'd0, 50, 2); cfg(2'd1, 50, 1);
    cfg(2'd2, 50, 1); cfg(2'd2, 5, 1); cfg(2'd2, 40, 1);
    probe("R4 lowest value", 1'b1, 50);
    cfg(2'd2, 20, 1);
    probe("R4 new best", 1'b1, 20);
    take(20);
    leave();
    take(50);
    leave();
    take(5);
    leave();
    take(40);
    leave();
    probe("R8 pending cleared", 1'b0, 0);

    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule